// File: doc/BRIEF.md
# Square-Root Carry-Select Adder, 16 Bit

This block adds two 16-bit unsigned operands and a carry-in, giving a 16-bit sum and a carry-out, with no clock and no storage. The operand is split into five slices of growing width (2, 2, 3, 4 and 5 bits, least significant first). The bottom slice is a plain ripple adder fed by the external carry-in. Every higher slice computes its result once, assuming an incoming carry of zero. A small increment-by-one network turns that result into the answer for an incoming carry of one. The real carry from the slice below then steers a multiplexer between the two.

Each increment network spans the slice's sum bits plus its carry bit. Its top output bit is an OR of the top input with the AND of all lower inputs, not an XOR. The zero-carry result can never be all ones, so the OR is safe. The block is written as explicit gate equations and is meant to sit in a wider datapath where its depth is dominated by the carry-select chain, not a full ripple.

Top module: `sqrt_csel_add16`

## Requirements
- R1: `{carry_out, sum}` equals the 17-bit value `op_a + op_b + carry_in` for every input combination.
- R2: The operand is partitioned into slices of 2, 2, 3, 4 and 5 bits from bit 0 upward. The bottom slice (bits 1:0) ripples directly from `carry_in`, and a carry crossing each slice boundary (bits 1, 3, 6, 10) reaches the sum correctly.
- R3: Each upper slice's zero-carry adder has a half adder at its lowest bit and full adders above it. Its (width+1)-bit result `{carry, sum}` never equals all ones, even when both slice operands are all ones.
- R4: The increment network of width N (N = 3, 4, 5, 6) outputs its input plus one, modulo 2^N, for every input from 0 to 2^N-2. Its top bit is formed with an OR.
- R5: In each upper slice, an incoming carry of 0 selects the zero-carry result and an incoming carry of 1 selects the incremented result; the sum bits and the slice carry are selected together.
- R6: `carry_out` is the carry chosen by the topmost (5-bit) slice's multiplexer. It is 1 exactly when the 17-bit total is at least 65536.
- R7: The block is purely combinational: outputs follow a change of any input with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the total |
| carry_out | output | 1 | Bit 16 of the total |

## Verification
The block holds no state, so any fault in a slice shows at the ports in the same time step as the input that exercises it. A wrong increment bit appears only when the incoming slice carry is 1 and the zero-carry result reaches the faulty pattern. A miswired multiplexer polarity corrupts every sum whose slice carry is set. Boundary operands that push a carry across each slice edge, and vectors driven into each increment network on its own, expose these faults without waiting for random stimulus to hit them.

// File: rtl/csa_pkg.sv
package csa_pkg;

    localparam int DATA_W  = 16;
    localparam int NUM_GRP = 5;

    // Width of slice g, least significant slice first.
    function automatic int grp_w(input int g);
        case (g)
            0:       return 2;
            1:       return 2;
            2:       return 3;
            3:       return 4;
            default: return 5;
        endcase
    endfunction

    // Bit position where slice g starts.
    function automatic int grp_lsb(input int g);
        int acc;
        acc = 0;
        for (int i = 0; i < g; i++) acc += grp_w(i);
        return acc;
    endfunction

    typedef struct packed {
        logic              cout;
        logic [DATA_W-1:0] sum;
    } add_res_t;

endpackage

// File: rtl/csa_fa.sv
module csa_fa (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    logic p;
    always_comb begin
        p  = a ^ b;
        s  = p ^ ci;
        co = (a & b) | (ci & p);
    end
endmodule

// File: rtl/csa_rip_group.sv
module csa_rip_group #(
    parameter int W = 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] c;
    assign c[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        csa_fa u_fa (.a(a[i]), .b(b[i]), .ci(c[i]), .s(s[i]), .co(c[i+1]));
    end

    assign co = c[W];

    always_comb begin
        p_rip_total_r2: assert ({co, s} == (W+1)'(a) + (W+1)'(b) + (W+1)'(ci))
            else $error("bottom slice total wrong");
    end
endmodule

// File: rtl/csa_xs1_conv.sv
module csa_xs1_conv #(
    parameter int W = 4
) (
    input  logic [W-1:0] c_in,
    output logic [W-1:0] x_out
);
    logic [W-1:0] pre;   // pre[i] = AND of c_in[i:0]
    assign pre[0] = c_in[0];
    for (genvar i = 1; i < W; i++) begin : g_pre
        assign pre[i] = pre[i-1] & c_in[i];
    end

    assign x_out[0] = ~c_in[0];
    for (genvar i = 1; i < W-1; i++) begin : g_mid
        assign x_out[i] = c_in[i] ^ pre[i-1];
    end
    // top bit: OR suffices since all-ones input never arrives
    assign x_out[W-1] = c_in[W-1] | pre[W-2];

    always_comb begin
        if (c_in != {W{1'b1}}) begin
            p_inc_by_one_r4: assert (x_out == c_in + W'(1))
                else $error("increment network wrong");
        end
    end
endmodule

// File: rtl/csa_sel_group.sv
module csa_sel_group #(
    parameter int W = 3
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel,
    output logic [W-1:0] s,
    output logic         co
);
    localparam int RW = W + 1;

    logic [W:0]    c;
    logic [W-1:0]  s0;
    logic [RW-1:0] zero_res;
    logic [RW-1:0] one_res;

    // half adder at the bottom bit
    assign s0[0] = a[0] ^ b[0];
    assign c[1]  = a[0] & b[0];
    assign c[0]  = 1'b0;

    for (genvar i = 1; i < W; i++) begin : g_bit
        csa_fa u_fa (.a(a[i]), .b(b[i]), .ci(c[i]), .s(s0[i]), .co(c[i+1]));
    end

    assign zero_res = {c[W], s0};

    csa_xs1_conv #(.W(RW)) u_conv (.c_in(zero_res), .x_out(one_res));

    assign {co, s} = sel ? one_res : zero_res;

    always_comb begin
        p_zero_never_full_r3: assert (zero_res != {RW{1'b1}})
            else $error("zero-carry result all ones");
        if (!sel) begin
            p_pick_zero_r5: assert ({co, s} == RW'(a) + RW'(b))
                else $error("carry-0 selection wrong");
        end else begin
            p_pick_one_r5: assert ({co, s} == RW'(a) + RW'(b) + RW'(1))
                else $error("carry-1 selection wrong");
        end
    end
endmodule

// File: rtl/sqrt_csel_add16.sv
module sqrt_csel_add16
    import csa_pkg::*;
(
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    input  logic        carry_in,
    output logic [15:0] sum,
    output logic        carry_out
);
    logic [NUM_GRP:0] gc;
    add_res_t         res;

    assign gc[0] = carry_in;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int GW  = grp_w(g);
        localparam int LSB = grp_lsb(g);
        if (g == 0) begin : g_base
            csa_rip_group #(.W(GW)) u_grp (
                .a (op_a[LSB +: GW]),
                .b (op_b[LSB +: GW]),
                .ci(gc[g]),
                .s (res.sum[LSB +: GW]),
                .co(gc[g+1])
            );
        end else begin : g_sel
            csa_sel_group #(.W(GW)) u_grp (
                .a  (op_a[LSB +: GW]),
                .b  (op_b[LSB +: GW]),
                .sel(gc[g]),
                .s  (res.sum[LSB +: GW]),
                .co (gc[g+1])
            );
        end
    end

    assign res.cout = gc[NUM_GRP];
    assign sum       = res.sum;
    assign carry_out = res.cout;

    always_comb begin
        p_total_r1: assert ({carry_out, sum} == 17'(op_a) + 17'(op_b) + 17'(carry_in))
            else $error("adder total wrong");
        p_cout_bound_r6: assert (carry_out == ((17'(op_a) + 17'(op_b) + 17'(carry_in)) >= 17'd65536))
            else $error("carry-out wrong");
    end
endmodule

// File: tb/tb_sqrt_csel_add16.sv
`timescale 1ns/1ps
module tb_sqrt_csel_add16;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [15:0] op_a = '0, op_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum;
    logic        carry_out;

    sqrt_csel_add16 dut (.op_a(op_a), .op_b(op_b), .carry_in(carry_in),
                         .sum(sum), .carry_out(carry_out));

    logic [2:0] cv3 = '0; logic [2:0] xo3;
    logic [3:0] cv4 = '0; logic [3:0] xo4;
    logic [4:0] cv5 = '0; logic [4:0] xo5;
    logic [5:0] cv6 = '0; logic [5:0] xo6;
    csa_xs1_conv #(.W(3)) u_c3 (.c_in(cv3), .x_out(xo3));
    csa_xs1_conv #(.W(4)) u_c4 (.c_in(cv4), .x_out(xo4));
    csa_xs1_conv #(.W(5)) u_c5 (.c_in(cv5), .x_out(xo5));
    csa_xs1_conv #(.W(6)) u_c6 (.c_in(cv6), .x_out(xo6));

    int checks = 0, failures = 0;
    bit done = 0;

    function automatic logic [16:0] ref_total(logic [15:0] a, logic [15:0] b, logic c);
        return {1'b0, a} + {1'b0, b} + {16'd0, c};
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic apply(string tag, logic [15:0] a, logic [15:0] b, logic c);
        logic [16:0] e;
        @(negedge clk);
        op_a = a; op_b = b; carry_in = c;
        #1;
        e = ref_total(a, b, c);
        chk(tag, {15'd0, carry_out, sum}, {15'd0, e});
    endtask

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd6119);
        // reset-like state: all zero inputs
        #1;
        chk("R1 zero", {15'd0, carry_out, sum}, 32'd0);
        // R7: input change with no clock edge, output follows
        op_a = 16'h1234; op_b = 16'h0F0F; #1;
        chk("R7 comb follow", {15'd0, carry_out, sum}, {15'd0, ref_total(16'h1234, 16'h0F0F, 1'b0)});
        carry_in = 1'b1; #1;
        chk("R7 comb cin", {15'd0, carry_out, sum}, {15'd0, ref_total(16'h1234, 16'h0F0F, 1'b1)});

        for (int c = 0; c < 2; c++) begin
            apply("R1 zeros",   16'h0000, 16'h0000, c[0]);
            apply("R1 ones",    16'hFFFF, 16'hFFFF, c[0]);
            apply("R1 alt",     16'hAAAA, 16'h5555, c[0]);
            apply("R1 alt2",    16'h5555, 16'h5555, c[0]);
            apply("R1 alt3",    16'hAAAA, 16'hAAAA, c[0]);
            apply("R6 wrap",    16'hFFFF, 16'h0000, c[0]);
            apply("R6 top",     16'h8000, 16'h8000, c[0]);
        end
        // R2: carry across each slice edge (bits 1, 3, 6, 10)
        apply("R2 edge1",  16'h0003, 16'h0000, 1'b1);
        apply("R2 edge3",  16'h000F, 16'h0001, 1'b0);
        apply("R2 edge6",  16'h007F, 16'h0001, 1'b0);
        apply("R2 edge10", 16'h07FF, 16'h0000, 1'b1);
        // R3/R5: each upper slice with both operands all ones, carry in 0 and 1
        apply("R3 s1 max", 16'h000C, 16'h000C, 1'b0);
        apply("R5 s1 sel", 16'h000F, 16'h000C, 1'b1);
        apply("R3 s2 max", 16'h0070, 16'h0070, 1'b0);
        apply("R5 s2 sel", 16'h007F, 16'h0071, 1'b0);
        apply("R3 s3 max", 16'h0780, 16'h0780, 1'b0);
        apply("R5 s3 sel", 16'h07C0, 16'h07C0, 1'b0);
        apply("R3 s4 max", 16'hF800, 16'hF800, 1'b0);
        apply("R6 s4 sel", 16'hFC00, 16'hFC00, 1'b1);

        // R4: each increment network over all reachable inputs
        for (int v = 0; v < 7; v++)  begin cv3 = 3'(v); #1; chk("R4 w3", {29'd0, xo3}, {29'd0, 3'(v + 1)}); end
        for (int v = 0; v < 15; v++) begin cv4 = 4'(v); #1; chk("R4 w4", {28'd0, xo4}, {28'd0, 4'(v + 1)}); end
        for (int v = 0; v < 31; v++) begin cv5 = 5'(v); #1; chk("R4 w5", {27'd0, xo5}, {27'd0, 5'(v + 1)}); end
        for (int v = 0; v < 63; v++) begin cv6 = 6'(v); #1; chk("R4 w6", {26'd0, xo6}, {26'd0, 6'(v + 1)}); end

        // R1: random vectors
        for (int n = 0; n < 100000; n++) begin
            logic [31:0] r;
            r = $urandom();
            apply("R1 rand", r[15:0], r[31:16], 1'($urandom()));
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule